// File: doc/BRIEF.md
# Indirect Dword Window onto a Hot-Plug Register Array

This block places a small eight-byte window in front of a larger byte-addressed register array. The window holds a select byte and a 32-bit data field. The data field always shows the array dword at byte address `select * 4`. Software can therefore reach every dword of the array through two fixed locations. A write that lands on the data field is passed on as a full four-byte write to the selected dword. The data field is then reloaded from the array, so it shows whatever the array kept, for example after write-one-to-clear rules.

A second port gives direct byte-addressed access of one to four bytes, little-endian. The access length is trimmed at the end of the array. Addresses past the end read as zero and drop writes. The array sits outside the block and is reached through one combinational read / registered write port. The array holds `0x24 + 4 * NSLOTS` bytes. The address space is sized for the largest build (31 slots) rounded up to a power of two.

A three-state controller orders the work. `S_IDLE` accepts accesses. `S_FWD` issues the forwarded array write. `S_REFRESH` reloads the data field. The transitions are as follows:
- `S_IDLE -> S_FWD` on a window write that touches the data field.
- `S_IDLE -> S_REFRESH` on any other window write, or on any direct write.
- `S_FWD -> S_REFRESH` always.
- `S_REFRESH -> S_IDLE` always.

Both ports are held off while the controller is outside `S_IDLE`.

Top module: `dsel_window`

## Requirements
- R1: After reset, every window byte reads zero (with the flag inputs low), both ports report ready, and no array write is issued.
- R2: A window read of length code n (n+1 bytes, little-endian) starting at offset a returns image bytes a..a+n, where bytes 0 and 1 are zero, byte 2 is the select value, byte 3 carries the two flag inputs in bits 2 and 3, and bytes 4..7 are the data field; bytes past offset 7 read zero.
- R3: A window write covering offset 2 loads the select byte; once the controller is idle again, the data field equals the array dword at select*4.
- R4: A window write touching any of offsets 4..7 updates those data bytes and, in the next cycle, issues one array write of all four bytes at select*4 carrying the whole data field; the data field is reloaded in the cycle after that.
- R5: When select*4 is at or beyond the array size, no array write is forwarded and the data field reads zero after reload.
- R6: A direct read of length code n at address a returns array byte a+i in lane i for i <= n and a+i inside the array, zero elsewhere, one cycle after acceptance.
- R7: A direct write enables only lanes i <= n with a+i inside the array; nothing is written at or past the array end.
- R8: While the controller is outside S_IDLE both ready outputs are low; a data-field write holds the window off for exactly two cycles, any other write for one.
- R9: A direct write is followed by a reload of the data field, so the window reflects bytes just written into the selected dword.
- R10: Window writes to offsets 0, 1 and 3 change no readable state and forward nothing.
- R11: When both ports request in the same idle cycle, the window access is taken and the direct port is held off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_req | input | 1 | Window access request |
| win_we | input | 1 | Window access is a write |
| win_addr | input | 3 | Window byte offset |
| win_len | input | 2 | Window length code (bytes minus one) |
| win_wdata | input | 32 | Window write data, lane 0 at bits 7:0 |
| win_ready | output | 1 | Window request accepted this cycle when high |
| win_rvalid | output | 1 | Window read data valid |
| win_rdata | output | 32 | Window read data |
| cap_flags | input | 2 | Read-only flags shown in byte 3 bits 2 and 3 |
| dir_req | input | 1 | Direct access request |
| dir_we | input | 1 | Direct access is a write |
| dir_addr | input | ADDR_W | Direct byte address |
| dir_len | input | 2 | Direct length code (bytes minus one) |
| dir_wdata | input | 32 | Direct write data, lane 0 at bits 7:0 |
| dir_ready | output | 1 | Direct request accepted this cycle when high |
| dir_rvalid | output | 1 | Direct read data valid |
| dir_rdata | output | 32 | Direct read data |
| bk_we | output | 1 | Array write strobe |
| bk_addr | output | ADDR_W | Array byte address of lane 0 |
| bk_be | output | 4 | Array lane enables |
| bk_wdata | output | 32 | Array write data |
| bk_rdata | input | 32 | Array bytes at bk_addr..bk_addr+3 |

## Verification
The bench uses a two-slot array of 44 bytes. Direct reads are swept over every address up to just past the end and every length. This separates correct lane masking from an off-by-one at the array boundary. Window reads are swept over all eight offsets and four lengths, which exposes any misplacement in the image and any failure to clip at offset 7. The select value is swept through in-range and out-of-range dwords, and forwarded writes are sent at each of them. These sweeps tell a forward to the wrong address, a missing or extra forward and a stale reload apart. Partial data writes, header-byte writes, a direct write into the selected dword and a same-cycle request on both ports each have their own pattern.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_FWD     = 2'd1,
        S_REFRESH = 2'd2
    } dsw_state_e;

    localparam int unsigned HDR_BYTES  = 36;
    localparam int unsigned SLOT_BYTES = 4;
    localparam int unsigned MAX_SLOTS  = 31;
    localparam int unsigned WIN_BYTES  = 8;

    function automatic int unsigned pow2_ceil(input int unsigned x);
        int unsigned p;
        p = 1;
        for (int i = 0; i < 31; i++) begin
            if (p < x) p = p * 2;
        end
        return p;
    endfunction

    localparam int unsigned APERTURE = pow2_ceil(HDR_BYTES + SLOT_BYTES * MAX_SLOTS);

endpackage

// File: rtl/dsw_clip.sv
module dsw_clip #(
    parameter int unsigned BASE_W = 3,
    parameter int unsigned LIMIT  = 8
) (
    input  logic [BASE_W-1:0] base,
    input  logic [1:0]        len_code,
    output logic [3:0]        lane_ok
);
    localparam int unsigned POS_W = BASE_W + 2;
    localparam logic [POS_W-1:0] LIM = POS_W'(LIMIT);

    for (genvar gi = 0; gi < 4; gi++) begin : g_lane
        logic [POS_W-1:0] pos;
        assign pos = {2'b00, base} + POS_W'(gi);
        assign lane_ok[gi] = (2'(gi) <= len_code) && (pos < LIM);
    end

endmodule

// File: rtl/dsw_ctrl.sv
module dsw_ctrl
    import dsw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic win_wr_acc,
    input  logic data_touch,
    input  logic dir_wr_acc,
    output logic busy,
    output logic fwd_en,
    output logic refresh_en
);
    dsw_state_e st, st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = S_IDLE;
        unique case (st)
            S_IDLE: begin
                if (win_wr_acc)      st_nx = data_touch ? S_FWD : S_REFRESH;
                else if (dir_wr_acc) st_nx = S_REFRESH;
                else                 st_nx = S_IDLE;
            end
            S_FWD:     st_nx = S_REFRESH;
            S_REFRESH: st_nx = S_IDLE;
            default:   st_nx = S_IDLE;
        endcase
    end

    always_comb begin
        busy       = 1'b0;
        fwd_en     = 1'b0;
        refresh_en = 1'b0;
        unique case (st)
            S_IDLE:    busy = 1'b0;
            S_FWD:     begin busy = 1'b1; fwd_en = 1'b1; end
            S_REFRESH: begin busy = 1'b1; refresh_en = 1'b1; end
            default:   busy = 1'b0;
        endcase
    end

    // R4: a forward is always followed by a reload
    p_fwd_then_refresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_en |=> refresh_en);

    // R9: a lone direct write leads straight to a reload
    p_dir_write_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && dir_wr_acc && !win_wr_acc) |=> (refresh_en && !fwd_en));

endmodule

// File: rtl/dsw_regs.sv
module dsw_regs (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [3:0]  wr_lanes,
    input  logic [31:0] wr_data,
    input  logic        refresh_en,
    input  logic        refresh_hit,
    input  logic [31:0] refresh_data,
    input  logic [1:0]  flags,
    output logic [7:0]  sel,
    output logic [31:0] mirror,
    output logic        data_touch,
    output logic [63:0] image
);
    logic       sel_we;
    logic [7:0] sel_val;
    logic [3:0] dat_we;
    logic [7:0] dat_val [4];

    always_comb begin
        sel_we  = 1'b0;
        sel_val = '0;
        dat_we  = '0;
        for (int k = 0; k < 4; k++) dat_val[k] = '0;
        for (int i = 0; i < 4; i++) begin
            logic [2:0] off;
            off = wr_addr + 3'(i);
            if (wr_lanes[i]) begin
                if (off == 3'd2) begin
                    sel_we  = 1'b1;
                    sel_val = wr_data[8*i +: 8];
                end
                if (off[2]) begin
                    dat_we[off[1:0]]  = 1'b1;
                    dat_val[off[1:0]] = wr_data[8*i +: 8];
                end
            end
        end
    end

    assign data_touch = |dat_we;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel    <= '0;
            mirror <= '0;
        end else if (wr_en) begin
            if (sel_we) sel <= sel_val;
            for (int k = 0; k < 4; k++) begin
                if (dat_we[k]) mirror[8*k +: 8] <= dat_val[k];
            end
        end else if (refresh_en) begin
            mirror <= refresh_hit ? refresh_data : 32'h0;
        end
    end

    assign image = {mirror, 4'b0000, flags, 2'b00, sel, 16'h0000};

    // R3: select only moves on a window write covering offset 2
    p_sel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel_we) |=> $stable(sel));

    // R5: a reload from outside the array yields zero
    p_mirror_oob_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_en && !wr_en && !refresh_hit) |=> (mirror == 32'h0));

endmodule

// File: rtl/dsel_window.sv
module dsel_window
    import dsw_pkg::*;
#(
    parameter int unsigned NSLOTS = 31,
    localparam int unsigned ARR_BYTES = HDR_BYTES + SLOT_BYTES * NSLOTS,
    localparam int unsigned ADDR_W    = $clog2(APERTURE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_req,
    input  logic              win_we,
    input  logic [2:0]        win_addr,
    input  logic [1:0]        win_len,
    input  logic [31:0]       win_wdata,
    output logic              win_ready,
    output logic              win_rvalid,
    output logic [31:0]       win_rdata,
    input  logic [1:0]        cap_flags,
    input  logic              dir_req,
    input  logic              dir_we,
    input  logic [ADDR_W-1:0] dir_addr,
    input  logic [1:0]        dir_len,
    input  logic [31:0]       dir_wdata,
    output logic              dir_ready,
    output logic              dir_rvalid,
    output logic [31:0]       dir_rdata,
    output logic              bk_we,
    output logic [ADDR_W-1:0] bk_addr,
    output logic [3:0]        bk_be,
    output logic [31:0]       bk_wdata,
    input  logic [31:0]       bk_rdata
);
    logic        busy, fwd_en, refresh_en;
    logic        win_acc, dir_acc;
    logic [3:0]  wlanes, dlanes;
    logic [7:0]  sel;
    logic [31:0] mirror;
    logic        data_touch;
    logic [63:0] image;
    logic [9:0]  fwd_addr;
    logic        fwd_hit;
    logic [31:0] win_rd_bytes, dir_rd_bytes;

    assign win_ready = !busy;
    assign dir_ready = !busy && !win_req;
    assign win_acc   = win_req && win_ready;
    assign dir_acc   = dir_req && dir_ready;

    assign fwd_addr = {sel, 2'b00};
    assign fwd_hit  = (32'(fwd_addr) < ARR_BYTES);

    dsw_clip #(.BASE_W(3), .LIMIT(WIN_BYTES)) u_wclip (
        .base     (win_addr),
        .len_code (win_len),
        .lane_ok  (wlanes)
    );

    dsw_clip #(.BASE_W(ADDR_W), .LIMIT(ARR_BYTES)) u_dclip (
        .base     (dir_addr),
        .len_code (dir_len),
        .lane_ok  (dlanes)
    );

    dsw_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_wr_acc (win_acc && win_we),
        .data_touch (data_touch),
        .dir_wr_acc (dir_acc && dir_we),
        .busy       (busy),
        .fwd_en     (fwd_en),
        .refresh_en (refresh_en)
    );

    dsw_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (win_acc && win_we),
        .wr_addr      (win_addr),
        .wr_lanes     (wlanes),
        .wr_data      (win_wdata),
        .refresh_en   (refresh_en),
        .refresh_hit  (fwd_hit),
        .refresh_data (bk_rdata),
        .flags        (cap_flags),
        .sel          (sel),
        .mirror       (mirror),
        .data_touch   (data_touch),
        .image        (image)
    );

    // array port steering
    always_comb begin
        bk_addr  = dir_addr;
        bk_we    = dir_acc && dir_we && (|dlanes);
        bk_be    = dlanes;
        bk_wdata = dir_wdata;
        if (fwd_en) begin
            bk_addr  = fwd_addr[ADDR_W-1:0];
            bk_we    = fwd_hit;
            bk_be    = 4'hF;
            bk_wdata = mirror;
        end else if (refresh_en) begin
            bk_addr  = fwd_addr[ADDR_W-1:0];
            bk_we    = 1'b0;
            bk_be    = 4'hF;
        end
    end

    always_comb begin
        win_rd_bytes = '0;
        for (int i = 0; i < 4; i++) begin
            if (wlanes[i]) win_rd_bytes[8*i +: 8] = image[{win_addr + 3'(i), 3'b000} +: 8];
        end
    end

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            dir_rd_bytes[8*i +: 8] = dlanes[i] ? bk_rdata[8*i +: 8] : 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_rvalid <= 1'b0;
            win_rdata  <= '0;
            dir_rvalid <= 1'b0;
            dir_rdata  <= '0;
        end else begin
            win_rvalid <= win_acc && !win_we;
            dir_rvalid <= dir_acc && !dir_we;
            if (win_acc && !win_we) win_rdata <= win_rd_bytes;
            if (dir_acc && !dir_we) dir_rdata <= dir_rd_bytes;
        end
    end

    // R4: forwarded writes cover the whole dword
    p_fwd_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_en && bk_we) |-> (bk_be == 4'hF));

    // R7: no array write starts outside the array
    p_no_oob_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bk_we |-> (32'(bk_addr) < ARR_BYTES));

    // R6: an accepted direct read answers one cycle later
    p_dir_rvalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_req && !dir_we && dir_ready) |=> dir_rvalid);

    // R8: a window request during a busy cycle yields no read data next cycle
    p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_req && busy) |=> !win_rvalid);

endmodule

// File: tb/dsel_window_bench.sv
`timescale 1ns/1ps
module dsel_window_bench;
    localparam int unsigned NSLOTS = 2;
    localparam int unsigned ARR    = 36 + 4 * NSLOTS;
    localparam int unsigned AW     = $clog2(dsw_pkg::APERTURE);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          win_req = 0, win_we = 0;
    logic [2:0]    win_addr = 0;
    logic [1:0]    win_len = 0;
    logic [31:0]   win_wdata = 0;
    logic          win_ready, win_rvalid;
    logic [31:0]   win_rdata;
    logic [1:0]    cap_flags = 0;
    logic          dir_req = 0, dir_we = 0;
    logic [AW-1:0] dir_addr = 0;
    logic [1:0]    dir_len = 0;
    logic [31:0]   dir_wdata = 0;
    logic          dir_ready, dir_rvalid;
    logic [31:0]   dir_rdata;
    logic          bk_we;
    logic [AW-1:0] bk_addr;
    logic [3:0]    bk_be;
    logic [31:0]   bk_wdata, bk_rdata;

    dsel_window #(.NSLOTS(NSLOTS)) u_dsel_window (.*);

    logic [7:0] mem  [256];
    logic [7:0] refm [256];
    int wr_cnt = 0, oob_cnt = 0;
    logic [AW-1:0] last_addr;
    logic [3:0]    last_be;
    logic [31:0]   last_data;

    assign bk_rdata = {mem[8'(bk_addr + 8'd3)], mem[8'(bk_addr + 8'd2)],
                       mem[8'(bk_addr + 8'd1)], mem[bk_addr]};

    always @(posedge clk) begin
        if (bk_we) begin
            wr_cnt    <= wr_cnt + 1;
            last_addr <= bk_addr;
            last_be   <= bk_be;
            last_data <= bk_wdata;
            for (int i = 0; i < 4; i++) begin
                if (bk_be[i]) begin
                    mem[8'(bk_addr + 8'(i))] <= bk_wdata[8*i +: 8];
                    if (int'(bk_addr) + i >= ARR) oob_cnt <= oob_cnt + 1;
                end
            end
        end
    end

    int n_cmp = 0, n_bad = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_dword(input int a);
        if (a + 3 >= int'(ARR)) return 32'h0;
        return {refm[a+3], refm[a+2], refm[a+1], refm[a]};
    endfunction

    task automatic win_op(input bit we, input int a, input int l, input logic [31:0] d,
                          output logic [31:0] r);
        @(negedge clk);
        win_req = 1; win_we = we; win_addr = 3'(a); win_len = 2'(l); win_wdata = d;
        while (!win_ready) @(negedge clk);
        @(negedge clk);
        win_req = 0;
        r = win_rdata;
    endtask

    task automatic dir_op(input bit we, input int a, input int l, input logic [31:0] d,
                          output logic [31:0] r);
        @(negedge clk);
        dir_req = 1; dir_we = we; dir_addr = AW'(a); dir_len = 2'(l); dir_wdata = d;
        while (!dir_ready) @(negedge clk);
        @(negedge clk);
        dir_req = 0;
        r = dir_rdata;
        if (we) begin
            for (int i = 0; i <= l; i++) begin
                if (a + i < int'(ARR)) refm[a+i] = d[8*i +: 8];
            end
        end
    endtask

    task automatic set_sel(input int s);
        logic [31:0] r;
        win_op(1, 2, 0, 32'(s & 8'hFF), r);
    endtask

    logic [31:0] rd;
    bit done = 0;

    initial begin
        for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; refm[i] = 8'h00; end
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 win_ready", 32'(win_ready), 32'd1);
        chk("R1 dir_ready", 32'(dir_ready), 32'd1);
        chk("R1 bk_we", 32'(bk_we), 32'd0);
        win_op(0, 0, 3, 0, rd); chk("R1 window low", rd, 32'h0);
        win_op(0, 4, 3, 0, rd); chk("R1 window high", rd, 32'h0);

        // fill the array directly
        for (int a = 0; a < int'(ARR); a++) begin
            dir_op(1, a, 0, 32'((a * 29 + 7) & 8'hFF), rd);
            if (a == 0) chk("R8 busy after direct write", 32'(dir_ready), 32'd0);
        end
        // R7 writes running past the end
        for (int a = 40; a < 51; a++) dir_op(1, a, 3, 32'hC0DE0000 | 32'(a), rd);
        repeat (2) @(negedge clk);
        chk("R7 out-of-range lanes", 32'(oob_cnt), 32'd0);
        for (int a = int'(ARR); a < 60; a++) chk("R7 beyond end untouched", 32'(mem[a]), 32'h0);
        for (int a = 0; a < int'(ARR); a++) chk("R7 array content", 32'(mem[a]), 32'(refm[a]));

        // R6 direct read sweep
        for (int a = 0; a < 48; a++) begin
            for (int l = 0; l < 4; l++) begin
                logic [31:0] e;
                e = 0;
                for (int i = 0; i <= l; i++) if (a + i < int'(ARR)) e[8*i +: 8] = refm[a+i];
                dir_op(0, a, l, 0, rd);
                chk("R6 direct read", rd, e);
            end
        end

        // R3 / R5 select sweep
        for (int s = 0; s < 17; s++) begin
            int sv;
            sv = (s == 16) ? 255 : s;
            set_sel(sv);
            if (s == 0) chk("R8 one-cycle hold after select write", 32'(win_ready), 32'd0);
            win_op(0, 2, 0, 0, rd); chk("R3 select byte", rd, 32'(sv));
            win_op(0, 4, 3, 0, rd);
            chk(sv * 4 < int'(ARR) ? "R3 mirror" : "R5 mirror zero", rd, ref_dword(sv * 4));
        end

        // R2 window image sweep
        cap_flags = 2'b10;
        set_sel(3);
        for (int a = 0; a < 8; a++) begin
            for (int l = 0; l < 4; l++) begin
                logic [63:0] img;
                logic [31:0] e;
                img = {ref_dword(12), 8'h08, 8'd3, 16'h0};
                e = 0;
                for (int i = 0; i <= l; i++) if (a + i < 8) e[8*i +: 8] = img[8*(a+i) +: 8];
                win_op(0, a, l, 0, rd);
                chk("R2 window read", rd, e);
            end
        end

        // R4 / R5 / R8 data write sweep
        for (int s = 0; s < 13; s++) begin
            int wc0;
            logic [31:0] v;
            set_sel(s);
            wc0 = wr_cnt;
            v = 32'hA5C30000 | 32'(s << 8) | 32'(s);
            win_op(1, 4, 3, v, rd);
            chk("R8 hold cycle 1", 32'(win_ready), 32'd0);
            @(negedge clk);
            chk("R8 hold cycle 2", 32'(win_ready), 32'd0);
            @(negedge clk);
            chk("R8 released", 32'(win_ready), 32'd1);
            if (s * 4 < int'(ARR)) begin
                chk("R4 forward count", 32'(wr_cnt), 32'(wc0 + 1));
                chk("R4 forward addr", 32'(last_addr), 32'(s * 4));
                chk("R4 forward be", 32'(last_be), 32'hF);
                chk("R4 forward data", last_data, v);
                for (int i = 0; i < 4; i++) refm[s*4+i] = v[8*i +: 8];
                win_op(0, 4, 3, 0, rd); chk("R4 reload", rd, v);
            end else begin
                chk("R5 no forward", 32'(wr_cnt), 32'(wc0));
                win_op(0, 4, 3, 0, rd); chk("R5 reload zero", rd, 32'h0);
            end
        end

        // R4 partial data writes
        begin
            logic [31:0] e;
            set_sel(5);
            e = (ref_dword(20) & 32'hFFFF00FF) | 32'h00003C00;
            win_op(1, 5, 0, 32'h0000003C, rd);
            repeat (2) @(negedge clk);
            chk("R4 partial forward", last_data, e);
            for (int i = 0; i < 4; i++) refm[20+i] = e[8*i +: 8];
            e = {16'h3344, ref_dword(20)[15:0]};
            win_op(1, 6, 3, 32'h11223344, rd);
            repeat (2) @(negedge clk);
            chk("R4 clipped forward", last_data, e);
            for (int i = 0; i < 4; i++) refm[20+i] = e[8*i +: 8];
        end

        // R10 header bytes
        begin
            int wc0;
            wc0 = wr_cnt;
            win_op(1, 0, 3, 32'hEE07DDCC, rd);
            win_op(0, 0, 3, 0, rd);
            chk("R10 header bytes", rd, 32'h08070000);
            chk("R10 no forward", 32'(wr_cnt), 32'(wc0));
        end

        // R11 simultaneous requests
        @(negedge clk);
        win_req = 1; win_we = 0; win_addr = 3'd2; win_len = 2'd0;
        dir_req = 1; dir_we = 0; dir_addr = '0; dir_len = 2'd0;
        #0;
        chk("R11 direct held", 32'(dir_ready), 32'd0);
        chk("R11 window taken", 32'(win_ready), 32'd1);
        @(negedge clk);
        chk("R11 window answered", 32'(win_rvalid), 32'd1);
        chk("R11 direct not answered", 32'(dir_rvalid), 32'd0);
        win_req = 0;
        @(negedge clk);
        dir_req = 0;
        chk("R11 direct answered", 32'(dir_rvalid), 32'd1);
        chk("R11 direct data", dir_rdata, 32'(refm[0]));

        // R9 direct write seen through the window
        set_sel(2);
        dir_op(1, 9, 0, 32'h5A, rd);
        win_op(0, 4, 3, 0, rd);
        chk("R9 reload after direct write", rd, ref_dword(8));

        for (int a = 0; a < int'(ARR); a++) chk("R4 final array", 32'(mem[a]), 32'(refm[a]));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule